// File: doc/BRIEF.md
# Multi-channel general purpose timer

This peripheral holds a parameterised number of independent up-counting timer channels behind a single-cycle register bus made of an address, a write strobe, write data and registered read data. Every channel has its own control, clock-setup, counter and compare registers. Firmware gives each channel one of three operating modes: a one-shot delay that stops itself, an auto-repeating period, or a free-running count that wraps. A channel counts either a fast system tick or a slow real-time tick. Both ticks arrive as one-cycle enable pulses, and either can be halved by a per-channel prescaler.

A compare match raises that channel's pending flag. Shared registers hold a per-channel interrupt enable and a write-one-to-acknowledge view of the pending flags. The single interrupt level output is high while any enabled channel has a pending flag. The main uses are a periodic system tick, a one-shot next-event timer and a free-running time base that software can read at any moment.

Top module: `mt_timer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq` is low.
- R2: Channel n (n from 1 to NUM_CH) owns the bank at byte offset 16*n. Control is at +0x0: bit 0 is enable, bits [5:4] are the mode, and all other bits read 0. Clock setup is at +0x4: bit 4 is the source and bit 0 is the divider, and all other bits read 0. The counter is at +0x8. Compare is at +0xC and holds CNT_W bits. The interrupt-enable register is at 0x00 and uses bit n-1 for channel n. Read data appears on the clock edge after the address is presented.
- R3: An enabled channel adds one to its counter on every counted tick. A disabled channel holds its counter.
- R4: Clock-setup bit 4 set to 0 selects `fast_tick`. Set to 1, it selects `slow_tick`. The tick that is not selected has no effect on the counter.
- R5: With clock-setup bit 0 set, only every second selected tick is counted. The first counted tick is the second one after the most recent control write.
- R6: Writing control with bit 1 set zeroes the counter in that cycle. Bit 1 always reads back as 0. A tick that arrives in the same cycle as any control write is not counted.
- R7: In mode 0, and in the reserved mode 2, the tick that makes the counter equal to compare leaves the counter at compare, sets the channel's pending flag and clears the channel's enable bit.
- R8: In mode 1, the tick that would make the counter equal to compare loads zero instead and sets the pending flag. The channel keeps running, so the period is the compare value in ticks. A compare value of 3 is supported.
- R9: In mode 3, a match sets the pending flag and the counter keeps running. After all ones, the counter wraps to zero.
- R10: Offset 0x08 reads the pending flags, with bit n-1 for channel n. Writing 1 to a bit clears that flag, and bits written as 0 are left alone. A match in the same cycle as the acknowledge leaves the flag set.
- R11: `irq` rises one cycle after any pending flag and its enable bit are both set, and falls one cycle after no such pair remains.
- R12: Unmapped offsets read zero and ignore writes. Writes to a counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| fast_tick | input | 1 | Fast system tick, one-cycle pulse |
| slow_tick | input | 1 | Slow real-time tick, one-cycle pulse |
| irq | output | 1 | Registered interrupt level |

## Verification
A tick driven in one cycle changes the counter and the pending flags at the clock edge that samples it. Read data for an address shows up at the following edge, and `irq` follows the pending flags one edge later. The bench applies every tick, write or read as a pulse that lasts one cycle, launched at a falling edge. It samples `bus_rdata` and `irq` only at a falling edge after a full register read, which is always at least two edges after the last stimulus. Collisions that must fall in one cycle, such as a tick with an acknowledge or a tick with a control write, are driven within that single cycle.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_RSVD   = 2'd2,
    MODE_FREE   = 2'd3
  } mt_mode_e;

  localparam int DATA_W = 32;

  // offsets inside a channel bank
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CLK  = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [3:0] OFS_CMP  = 4'hC;

  // offsets inside the shared bank (bank 0)
  localparam logic [3:0] OFS_IEN  = 4'h0;
  localparam logic [3:0] OFS_PEND = 4'h8;

  // field positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_DIV_BIT   = 0;
  localparam int CLK_SRC_BIT   = 4;

endpackage

// File: rtl/mt_prescale.sv
`timescale 1ns/1ps
module mt_prescale (
  input  logic clk,
  input  logic rst,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic src_slow,
  input  logic div2,
  input  logic run,
  input  logic restart,
  output logic tick_out
);

  logic sel_tick;
  logic phase_q;

  assign sel_tick = src_slow ? slow_tick : fast_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else if (restart) begin
      phase_q <= 1'b0;
    end else if (run && sel_tick && div2) begin
      phase_q <= ~phase_q;
    end
  end

  assign tick_out = sel_tick & (~div2 | phase_q);

endmodule

// File: rtl/mt_channel.sv
`timescale 1ns/1ps
module mt_channel
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             ctrl_we,
  input  logic             wr_en,
  input  logic             wr_clr,
  input  logic [1:0]       wr_mode,
  input  logic             clk_we,
  input  logic             wr_src,
  input  logic             wr_div,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wr_cmp,
  output logic             en_q,
  output logic [1:0]       mode_q,
  output logic             src_q,
  output logic             div_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             match
);

  logic             tick;
  logic             step;
  logic [CNT_W-1:0] cnt_inc;
  mt_mode_e         mode_e;

  assign mode_e = mt_mode_e'(mode_q);

  mt_prescale u_pre (
    .clk       (clk),
    .rst       (rst),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .src_slow  (src_q),
    .div2      (div_q),
    .run       (en_q),
    .restart   (ctrl_we),
    .tick_out  (tick)
  );

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign step    = en_q & tick & ~ctrl_we;
  assign match   = step & (cnt_inc == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 2'd0;
      cnt_q  <= '0;
    end else if (ctrl_we) begin
      en_q   <= wr_en;
      mode_q <= wr_mode;
      if (wr_clr) cnt_q <= '0;
    end else if (step) begin
      if (match) begin
        unique case (mode_e)
          MODE_REPEAT: cnt_q <= '0;
          MODE_FREE:   cnt_q <= cnt_inc;
          default: begin
            cnt_q <= cnt_inc;
            en_q  <= 1'b0;
          end
        endcase
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (clk_we) begin
        src_q <= wr_src;
        div_q <= wr_div;
      end
      if (cmp_we) cmp_q <= wr_cmp;
    end
  end

endmodule

// File: rtl/mt_timer.sv
`timescale 1ns/1ps
module mt_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic              irq
);

  localparam int BANK_W = ADDR_W - 4;

  logic [BANK_W-1:0] bank;
  logic [3:0]        ofs;
  logic              shared_sel;
  logic              ien_we;
  logic              ack_we;

  logic [NUM_CH-1:0]            ien_q;
  logic [NUM_CH-1:0]            pend_q;
  logic [NUM_CH-1:0]            match_v;
  logic [NUM_CH-1:0]            en_v;
  logic [NUM_CH-1:0][1:0]       mode_v;
  logic [NUM_CH-1:0]            src_v;
  logic [NUM_CH-1:0]            div_v;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_all;

  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  assign bank       = bus_addr[ADDR_W-1:4];
  assign ofs        = bus_addr[3:0];
  assign shared_sel = (bank == '0);
  assign ien_we     = bus_we & shared_sel & (ofs == OFS_IEN);
  assign ack_we     = bus_we & shared_sel & (ofs == OFS_PEND);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_sel;
    assign ch_sel = (bank == BANK_W'(i + 1));

    mt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .ctrl_we   (bus_we & ch_sel & (ofs == OFS_CTRL)),
      .wr_en     (bus_wdata[CTRL_EN_BIT]),
      .wr_clr    (bus_wdata[CTRL_CLR_BIT]),
      .wr_mode   (bus_wdata[CTRL_MODE_LSB+1:CTRL_MODE_LSB]),
      .clk_we    (bus_we & ch_sel & (ofs == OFS_CLK)),
      .wr_src    (bus_wdata[CLK_SRC_BIT]),
      .wr_div    (bus_wdata[CLK_DIV_BIT]),
      .cmp_we    (bus_we & ch_sel & (ofs == OFS_CMP)),
      .wr_cmp    (bus_wdata[CNT_W-1:0]),
      .en_q      (en_v[i]),
      .mode_q    (mode_v[i]),
      .src_q     (src_v[i]),
      .div_q     (div_v[i]),
      .cnt_q     (cnt_all[i]),
      .cmp_q     (cmp_all[i]),
      .match     (match_v[i])
    );
  end

  // shared interrupt state
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ien_we) ien_q <= bus_wdata[NUM_CH-1:0];
      pend_q <= (pend_q & ~(ack_we ? bus_wdata[NUM_CH-1:0] : '0)) | match_v;
      irq_q  <= |(pend_q & ien_q);
    end
  end

  // read mux, registered
  always_comb begin
    rd_d = '0;
    if (shared_sel) begin
      if (ofs == OFS_IEN)  rd_d = DATA_W'(ien_q);
      if (ofs == OFS_PEND) rd_d = DATA_W'(pend_q);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (bank == BANK_W'(i + 1)) begin
        unique case (ofs)
          OFS_CTRL: rd_d = DATA_W'({mode_v[i], 3'b000, en_v[i]});
          OFS_CLK:  rd_d = DATA_W'({src_v[i], 3'b000, div_v[i]});
          OFS_CNT:  rd_d = DATA_W'(cnt_all[i]);
          OFS_CMP:  rd_d = DATA_W'(cmp_all[i]);
          default:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/mt_timer_chk.sv
`timescale 1ns/1ps
module mt_timer_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic                           bus_we,
  input logic [NUM_CH-1:0]              ack_bits,
  input logic [31:0]                    bus_rdata,
  input logic                           irq,
  input logic [NUM_CH-1:0]              pend_q,
  input logic [NUM_CH-1:0]              ien_q,
  input logic [NUM_CH-1:0]              match_v,
  input logic [NUM_CH-1:0]              en_v,
  input logic [NUM_CH-1:0][1:0]         mode_v,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_all
);

  logic [ADDR_W-5:0] c_bank;
  logic [3:0]        c_ofs;
  logic              c_mapped;
  logic              c_ack;

  assign c_bank   = bus_addr[ADDR_W-1:4];
  assign c_ofs    = bus_addr[3:0];
  assign c_mapped = ((c_bank == '0) && (c_ofs == 4'h0 || c_ofs == 4'h8)) ||
                    ((c_bank != '0) && (int'(c_bank) <= NUM_CH) && (c_ofs[1:0] == 2'b00));
  assign c_ack    = bus_we && (bus_addr == ADDR_W'(8));

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq && bus_rdata == 32'd0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !c_mapped |=> bus_rdata == 32'd0); // R12

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq); // R11

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (cnt_all[i] == $past(cnt_all[i])) ||
      (cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1)) ||
      (cnt_all[i] == '0)); // R3

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
      (match_v[i] && (mode_v[i] == 2'd0 || mode_v[i] == 2'd2)) |=> !en_v[i]); // R7

    AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (match_v[i] && mode_v[i] == 2'd1) |=> cnt_all[i] == '0); // R8

    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (rst)
      match_v[i] |=> pend_q[i]); // R10

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (c_ack && ack_bits[i] && !match_v[i]) |=> !pend_q[i]); // R10
  end

endmodule

bind mt_timer mt_timer_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .ack_bits  (bus_wdata[NUM_CH-1:0]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .pend_q    (pend_q),
  .ien_q     (ien_q),
  .match_v   (match_v),
  .en_v      (en_v),
  .mode_v    (mode_v),
  .cnt_all   (cnt_all)
);

// File: tb/sim_mt_timer.sv
`timescale 1ns/1ps
module sim_mt_timer;

  localparam int NCH = 3;
  localparam int CW  = 8;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ft = 1'b0;
  logic          st = 1'b0;
  logic          irq;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mt_timer #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .fast_tick (ft),
    .slow_tick (st),
    .irq       (irq)
  );

  function automatic logic [AW-1:0] ra(input int ch, input int o);
    return AW'(16 * ch + o);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdchk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); check(rdata, exp, tag);
  endtask

  task automatic ticks(input bit f, input bit s, input int n);
    repeat (n) begin
      @(negedge clk); ft = f; st = s;
      @(negedge clk); ft = 1'b0; st = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: everything zero after reset
    check(32'(irq), 0, "R1 irq");
    rdchk(ra(0, 0), 0, "R1 ien");
    rdchk(ra(0, 8), 0, "R1 pending");
    for (int c = 1; c <= NCH; c++) begin
      for (int o = 0; o < 16; o += 4) rdchk(ra(c, o), 0, "R1 channel reg");
    end

    // R2: readback masks
    wr(ra(2, 4), 32'hFFFF_FFFF);
    rdchk(ra(2, 4), 32'h11, "R2 clock setup");
    wr(ra(2, 12), 32'h1234_56AB);
    rdchk(ra(2, 12), 32'hAB, "R2 compare");
    wr(ra(2, 0), 32'hFFFF_FFFF);
    rdchk(ra(2, 0), 32'h31, "R2 control, R6 clear reads 0");
    wr(ra(2, 0), 0);
    wr(ra(0, 0), 32'hFFFF_FFFF);
    rdchk(ra(0, 0), 32'h7, "R2 ien");
    wr(ra(0, 0), 0);

    // R3/R4/R9 on channel 1, free run, compare 0
    wr(ra(1, 4), 0);
    wr(ra(1, 12), 0);
    wr(ra(1, 0), 32'h33);
    ticks(1, 0, 10);
    rdchk(ra(1, 8), 10, "R3 count");
    ticks(0, 1, 5);
    rdchk(ra(1, 8), 10, "R4 other source ignored");
    wr(ra(1, 0), 32'h30);
    ticks(1, 0, 5);
    rdchk(ra(1, 8), 10, "R3 hold when disabled");
    wr(ra(1, 0), 32'h31);
    ticks(1, 0, 245);
    rdchk(ra(1, 8), 255, "R9 near wrap");
    rdchk(ra(0, 8), 0, "R9 no match yet");
    ticks(1, 0, 1);
    rdchk(ra(1, 8), 0, "R9 wrap");
    rdchk(ra(0, 8), 1, "R9 pending");
    check(32'(irq), 0, "R11 masked");
    wr(ra(0, 8), 1);
    rdchk(ra(0, 8), 0, "R10 ack");
    wr(ra(1, 0), 0);

    // R4/R5 channel 3, slow source, divide by two
    wr(ra(3, 4), 32'h11);
    wr(ra(3, 12), 32'hF0);
    wr(ra(3, 0), 32'h33);
    for (int n = 1; n <= 8; n++) begin
      ticks(0, 1, 1);
      if (n == 4) ticks(1, 0, 3);
      rdchk(ra(3, 8), 32'(n / 2), "R5 divide by two");
    end
    wr(ra(3, 0), 0);

    // R7 one-shot on channel 2, compare 3
    wr(ra(0, 0), 2);
    wr(ra(2, 4), 0);
    wr(ra(2, 12), 3);
    wr(ra(2, 0), 32'h03);
    ticks(1, 0, 2);
    rdchk(ra(2, 8), 2, "R7 counting");
    rdchk(ra(0, 8), 0, "R7 no pending early");
    ticks(1, 0, 1);
    rdchk(ra(2, 8), 3, "R7 stop at compare");
    rdchk(ra(2, 0), 0, "R7 enable cleared");
    rdchk(ra(0, 8), 2, "R7 pending");
    check(32'(irq), 1, "R11 irq high");
    ticks(1, 0, 4);
    rdchk(ra(2, 8), 3, "R7 halted");
    wr(ra(0, 8), 2);
    rdchk(ra(0, 8), 0, "R10 ack channel 2");
    check(32'(irq), 0, "R11 irq low");
    wr(ra(2, 0), 32'h23);
    ticks(1, 0, 3);
    rdchk(ra(2, 0), 32'h20, "R7 reserved mode stops");
    rdchk(ra(2, 8), 3, "R7 reserved mode count");
    wr(ra(0, 8), 2);
    wr(ra(0, 0), 0);

    // R8 repeat on channel 1, compare 3
    wr(ra(1, 12), 3);
    wr(ra(1, 0), 32'h13);
    for (int n = 1; n <= 10; n++) begin
      ticks(1, 0, 1);
      rdchk(ra(1, 8), 32'(n % 3), "R8 repeat count");
    end
    rdchk(ra(0, 8), 1, "R8 pending");
    wr(ra(0, 8), 1);
    rdchk(ra(0, 8), 0, "R10 ack before collision");
    ticks(1, 0, 1);
    @(negedge clk); ft = 1'b1; addr = ra(0, 8); wdata = 1; we = 1'b1;
    @(negedge clk); ft = 1'b0; we = 1'b0;
    rdchk(ra(0, 8), 1, "R10 match wins over ack");
    rdchk(ra(1, 8), 0, "R8 reload");

    // R6 clear with a colliding tick
    ticks(1, 0, 2);
    rdchk(ra(1, 8), 2, "R6 before clear");
    @(negedge clk); ft = 1'b1; addr = ra(1, 0); wdata = 32'h13; we = 1'b1;
    @(negedge clk); ft = 1'b0; we = 1'b0;
    rdchk(ra(1, 8), 0, "R6 cleared, tick not counted");
    rdchk(ra(1, 0), 32'h11, "R6 clear bit reads 0");
    ticks(1, 0, 1);
    rdchk(ra(1, 8), 1, "R6 restart");

    // R11 enable gating
    wr(ra(0, 0), 1);
    rdchk(ra(0, 0), 1, "R11 ien set");
    check(32'(irq), 1, "R11 irq follows enable");
    wr(ra(0, 0), 0);
    rdchk(ra(0, 0), 0, "R11 ien clear");
    check(32'(irq), 0, "R11 irq drops");

    // R12 unmapped and read-only
    wr(ra(0, 4), 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(ra(1, 8), 32'h55);
    rdchk(ra(0, 4), 0, "R12 shared gap");
    rdchk(8'h40, 0, "R12 bank beyond channels");
    rdchk(8'h01, 0, "R12 odd offset");
    rdchk(8'h13, 0, "R12 unaligned channel offset");
    rdchk(8'hF8, 0, "R12 top bank");
    rdchk(ra(0, 0), 0, "R12 ien untouched");
    rdchk(ra(1, 12), 3, "R12 compare untouched");
    rdchk(ra(1, 8), 1, "R12 counter write ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule